// File: doc/BRIEF.md
# CCD Correlated Double Sampler

This block sits between an external video converter and the pixel pipeline of a linear CCD image sensor. It watches the two readout clocks produced by the sensor sequencer: the read-out reset pulse and the main register transfer clock. From them it issues two sample strobes to the converter, one for the reference level and one for the signal level. Each strobe fires a programmable number of cycles after the falling edge of its clock, so that the converter samples the settled level after that edge rather than the transient. Converter results come back with a valid flag. Each result is tagged by the strobe that asked for it, and every reference/signal pair is turned into one pixel.

The sensor runs in a preload readout mode. The raw difference, reference minus signal, is largest in darkness and falls to zero at saturation. The block therefore reports a light-proportional value, which is a stored preload value minus the difference, floored at zero. A saturation flag is set when the raw difference is below a programmable threshold.

The preload value is calibrated while lateral transfer is suppressed. In that state every pixel carries the full preload, and a calibration input makes the block average the differences of one line of pixels and store the result. While the read-enable input is low the sensor output holds a flat level. The block then issues no strobes and forms no pixels.

Top module: `cds_pixel_former`

## Requirements
- R1: The reference strobe `strobe_ref` is high for one cycle, starting at the D-th rising clock edge after the edge that first samples `rst_pulse` low following a high sample, with D = `ref_delay` (a value of 0 acts as 1).
- R2: The signal strobe `strobe_sig` is high for one cycle, starting at the D-th rising clock edge after the edge that first samples `xfer_clk` low following a high sample, with D = `sig_delay` (a value of 0 acts as 1).
- R3: Neither strobe is ever high for two consecutive cycles.
- R4: The first `adc_valid` sample after a reference strobe is stored as the reference. The first `adc_valid` sample after a signal strobe, when a reference is stored, forms a pixel. `pix_valid` is high for exactly one cycle, following the clock edge that accepted the signal sample.
- R5: The amplitude is the reference minus the signal, or 0 when the signal exceeds the reference.
- R6: `pix_data` is the stored preload minus the amplitude, or 0 when the amplitude exceeds the preload.
- R7: `pix_sat` is 1 exactly when the amplitude is below `sat_thresh`.
- R8: While `rd_en` is low, no strobe fires, no pixel is produced, and any stored reference is discarded.
- R9: While `cal_mode` is high, every NPIX (default 150) pixels load the preload with the floor of the mean of their amplitudes. Lowering `cal_mode` restarts the count.
- R10: After reset the preload is 2^W-1 (4095 for W=12) and `strobe_ref`, `strobe_sig` and `pix_valid` are low.
- R11: An `adc_valid` sample that follows no strobe is ignored and produces no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_pulse | input | 1 | Read-out reset clock phase from the sequencer |
| xfer_clk | input | 1 | Main register transfer clock phase from the sequencer |
| rd_en | input | 1 | Read enable; low means the sensor output is idle |
| cal_mode | input | 1 | Preload calibration enable |
| ref_delay | input | DW | Cycles from reset-pulse fall to reference strobe |
| sig_delay | input | DW | Cycles from transfer-clock fall to signal strobe |
| sat_thresh | input | W | Amplitude below which a pixel is flagged saturated |
| adc_data | input | W | Converter result |
| adc_valid | input | 1 | Converter result valid |
| strobe_ref | output | 1 | Converter sample request, reference level |
| strobe_sig | output | 1 | Converter sample request, signal level |
| pix_data | output | W | Light-proportional pixel value |
| pix_valid | output | 1 | Pixel output valid |
| pix_sat | output | 1 | Pixel saturation flag |

## Verification
The assertions assume that the sequencer holds each readout clock high for at least one cycle before it falls, so a strobe can never be re-armed in the cycle just after it fired. They also assume that the converter answers each strobe before the next strobe is issued. The stimulus drives each clock high for a full cycle before lowering it. It returns the converter sample one cycle after the strobe is seen and waits for the pixel before it starts the next pair. The bench therefore never overlaps a reference request with a signal request.

// File: rtl/cds_pixel_former.sv
module cds_pixel_former #(
  parameter int W    = 12,
  parameter int DW   = 8,
  parameter int NPIX = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_pulse,
  input  logic          xfer_clk,
  input  logic          rd_en,
  input  logic          cal_mode,
  input  logic [DW-1:0] ref_delay,
  input  logic [DW-1:0] sig_delay,
  input  logic [W-1:0]  sat_thresh,
  input  logic [W-1:0]  adc_data,
  input  logic          adc_valid,
  output logic          strobe_ref,
  output logic          strobe_sig,
  output logic [W-1:0]  pix_data,
  output logic          pix_valid,
  output logic          pix_sat
);
  localparam int CW = $clog2(NPIX + 1);
  localparam int AW = W + CW;
  localparam logic [1:0] T_NONE = 2'd0, T_REF = 2'd1, T_SIG = 2'd2;

  logic          rp_q, xc_q, rarm, sarm, have_ref;
  logic [DW-1:0] rcnt, scnt;
  logic [1:0]    want;
  logic [W-1:0]  ref_q, preload_q;
  logic [AW-1:0] acc;
  logic [CW-1:0] ccnt;

  wire rp_fall = rp_q & ~rst_pulse;
  wire xc_fall = xc_q & ~xfer_clk;
  wire [W-1:0] amp   = (ref_q > adc_data) ? ref_q - adc_data : '0;
  wire [W-1:0] light = (preload_q > amp) ? preload_q - amp : '0;
  wire pix_fire = rd_en & adc_valid & (want == T_SIG) & have_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp_q <= 1'b0; xc_q <= 1'b0;
      rarm <= 1'b0; sarm <= 1'b0;
      rcnt <= '0;   scnt <= '0;
      strobe_ref <= 1'b0; strobe_sig <= 1'b0;
    end else begin
      rp_q <= rst_pulse;
      xc_q <= xfer_clk;
      strobe_ref <= rd_en & ~rp_fall & rarm & (rcnt <= DW'(1));
      strobe_sig <= rd_en & ~xc_fall & sarm & (scnt <= DW'(1));
      if (!rd_en) rarm <= 1'b0;
      else if (rp_fall) begin rarm <= 1'b1; rcnt <= ref_delay; end
      else if (rarm) begin
        if (rcnt <= DW'(1)) rarm <= 1'b0;
        else rcnt <= rcnt - DW'(1);
      end
      if (!rd_en) sarm <= 1'b0;
      else if (xc_fall) begin sarm <= 1'b1; scnt <= sig_delay; end
      else if (sarm) begin
        if (scnt <= DW'(1)) sarm <= 1'b0;
        else scnt <= scnt - DW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      want <= T_NONE; have_ref <= 1'b0; ref_q <= '0;
      pix_valid <= 1'b0; pix_data <= '0; pix_sat <= 1'b0;
    end else begin
      pix_valid <= 1'b0;
      if (!rd_en) begin
        want <= T_NONE;
        have_ref <= 1'b0;
      end else begin
        if (adc_valid) begin
          want <= T_NONE;
          if (want == T_REF) begin
            ref_q <= adc_data;
            have_ref <= 1'b1;
          end else if (pix_fire) begin
            pix_valid <= 1'b1;
            pix_data  <= light;
            pix_sat   <= amp < sat_thresh;
            have_ref  <= 1'b0;
          end
        end
        if (strobe_ref) want <= T_REF;
        else if (strobe_sig) want <= T_SIG;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_q <= '1; acc <= '0; ccnt <= '0;
    end else if (!cal_mode) begin
      acc <= '0; ccnt <= '0;
    end else if (pix_fire) begin
      if (ccnt == CW'(NPIX - 1)) begin
        preload_q <= W'((acc + AW'(amp)) / AW'(NPIX));
        acc <= '0; ccnt <= '0;
      end else begin
        acc  <= acc + AW'(amp);
        ccnt <= ccnt + CW'(1);
      end
    end
  end

  assert_ref_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_ref |=> !strobe_ref);
  assert_sig_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_sig |=> !strobe_sig);
  assert_idle_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !strobe_ref && !strobe_sig && !pix_valid);
  assert_pix_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);
  assert_light_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> pix_data <= $past(preload_q));
  assert_dark_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_data == $past(preload_q) && $past(preload_q) != '0
      && $past(sat_thresh) != '0 |-> pix_sat);
endmodule

// File: tb/cds_pixel_former_bench.sv
module cds_pixel_former_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rst_pulse = 1'b0, xfer_clk = 1'b0, rd_en = 1'b0, cal_mode = 1'b0;
  logic [7:0]  ref_delay = 8'd4, sig_delay = 8'd2;
  logic [11:0] sat_thresh = 12'd16, adc_data = '0;
  logic adc_valid = 1'b0;
  logic strobe_ref, strobe_sig, pix_valid, pix_sat;
  logic [11:0] pix_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cds_pixel_former u_cds_pixel_former (
    .clk(clk), .rst_n(rst_n), .rst_pulse(rst_pulse), .xfer_clk(xfer_clk),
    .rd_en(rd_en), .cal_mode(cal_mode), .ref_delay(ref_delay),
    .sig_delay(sig_delay), .sat_thresh(sat_thresh), .adc_data(adc_data),
    .adc_valid(adc_valid), .strobe_ref(strobe_ref), .strobe_sig(strobe_sig),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_sat(pix_sat));

  // {reference, signal, expected light, expected sat}, preload 4095, threshold 16
  localparam logic [47:0] VEC [6] = '{
    {12'd3000, 12'd1000, 12'd2095, 12'd0},
    {12'd2000, 12'd2000, 12'd4095, 12'd1},
    {12'd1500, 12'd1600, 12'd4095, 12'd1},
    {12'd2000, 12'd1990, 12'd4085, 12'd1},
    {12'd2000, 12'd1984, 12'd4079, 12'd0},
    {12'd4095, 12'd0,    12'd0,    12'd0}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit sel, output int n);
    if (sel) xfer_clk = 1'b1; else rst_pulse = 1'b1;
    @(negedge clk);
    if (sel) xfer_clk = 1'b0; else rst_pulse = 1'b0;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); n++;
      if (sel ? strobe_sig : strobe_ref) break;
    end
  endtask

  task automatic send(logic [11:0] v);
    @(negedge clk); adc_data = v; adc_valid = 1'b1;
    @(negedge clk); adc_valid = 1'b0;
  endtask

  task automatic wait_pix(output bit got);
    got = 0;
    for (int i = 0; i < 6; i++) begin
      if (pix_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic form(logic [11:0] r, logic [11:0] s, output bit got);
    int n;
    pulse(0, n); send(r);
    pulse(1, n); send(s);
    wait_pix(got);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit got;
    logic [11:0] d;
    repeat (3) @(negedge clk);
    chk("R10 strobe_ref", strobe_ref, 0);
    chk("R10 strobe_sig", strobe_sig, 0);
    chk("R10 pix_valid", pix_valid, 0);
    rst_n = 1'b1; rd_en = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      form(VEC[k][47:36], VEC[k][35:24], got);
      chk("R4 pixel produced", got, 1);
      chk("R5 R6 light value", pix_data, VEC[k][23:12]);
      chk("R7 saturation flag", pix_sat, VEC[k][0]);
      @(negedge clk);
      chk("R4 valid one cycle", pix_valid, 0);
    end

    ref_delay = 8'd5; pulse(0, n);
    chk("R1 ref delay 5", n, 6);
    @(negedge clk); chk("R3 ref width", strobe_ref, 0);
    ref_delay = 8'd1; pulse(0, n);
    chk("R1 ref delay 1", n, 2);
    sig_delay = 8'd3; pulse(1, n);
    chk("R2 sig delay 3", n, 4);
    @(negedge clk); chk("R3 sig width", strobe_sig, 0);
    send(12'd100);
    chk("R11 no pixel from stray sig", pix_valid, 0);

    repeat (3) @(negedge clk);
    adc_data = 12'd5; adc_valid = 1'b1;
    @(negedge clk); adc_valid = 1'b0;
    @(negedge clk); chk("R11 stray sample ignored", pix_valid, 0);

    rd_en = 1'b0;
    pulse(0, n); chk("R8 no ref strobe while idle", n, 300);
    pulse(1, n); chk("R8 no sig strobe while idle", n, 300);
    rd_en = 1'b1;
    pulse(0, n); send(12'd3000);
    rd_en = 1'b0; @(negedge clk); rd_en = 1'b1;
    pulse(1, n); send(12'd1000); wait_pix(got);
    chk("R8 stored reference discarded", got, 0);

    ref_delay = 8'd4; sig_delay = 8'd2;
    cal_mode = 1'b1;
    for (int p = 0; p < 150; p++) begin
      form(12'd3000, (p % 2) ? 12'd1999 : 12'd2000, got);
      if (!got) chk("R9 calibration pixel", got, 1);
    end
    cal_mode = 1'b0;
    form(12'd3000, 12'd2700, got);
    chk("R9 calibrated preload applied", pix_data, 700);
    chk("R7 not saturated after cal", pix_sat, 0);
    form(12'd3000, 12'd1800, got);
    chk("R6 clamp at zero", pix_data, 0);

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    form(12'd1000, 12'd1000, got);
    chk("R10 preload reset to 4095", pix_data, 4095);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule